// File: doc/BRIEF.md
# Serial EEPROM Write Front End

This block is the bus-facing half of a small two-wire nonvolatile memory. It watches the clock and data lines through a fast system clock, recognises START and STOP conditions, compares the incoming device address against its own, takes one word-address byte into a pointer, and then accepts data bytes. It acknowledges each byte it accepts by pulling the open-drain data line low. Each accepted byte leaves the block as a one-cycle byte-write strobe with address and data. A STOP after at least one accepted byte raises a one-cycle commit pulse, which starts the array's internal write cycle.

The memory side reports its internal write cycle on a busy input. While busy is high, the block acknowledges nothing, not even its own address. A host can therefore poll for completion by repeatedly sending a write address until it is acknowledged. A write-protect input guards the upper half of the array. Its level is captured once per transfer, on the clock falling edge that ends the word-address acknowledge. When that captured level is high and the target lies in the upper half, the first data byte is refused and the rest of the transfer is ignored. Read transfers are not served: the block only stays off the data line.

Top module: `eeprom_wr_front`

## Requirements
- R1: A START (data falling while clock is high) begins a new device-address phase from any state, including in the middle of a transfer. A STOP (data rising while clock is high) returns the block to idle.
- R2: A device address byte whose upper seven bits equal parameter DEV_ADDR (default 7'h50) and whose last bit (read/write) is 0 is acknowledged. Any other address byte, including a matching one with the read bit set, leaves SDA untouched until the next START. This includes every later byte of that transfer.
- R3: An acknowledge holds SDA low from the first SCL falling edge after the eighth bit of a byte. SDA is released after the SCL falling edge that ends the ninth clock, so the line is free before the next bit.
- R4: The byte after an acknowledged device address is always acknowledged and loaded as the word address. The first data byte is written at exactly that address.
- R5: Each accepted data byte is acknowledged and produces exactly one wr_en_o pulse carrying the current pointer on wr_addr_o and the byte on wr_data_o.
- R6: After each accepted data byte, the low PAGE_BITS (default 4) bits of the pointer increment and wrap within the page. The upper bits stay unchanged, so the addresses run 0x3E, 0x3F, 0x30.
- R7: wp_i is sampled on the SCL falling edge that ends the word-address acknowledge. If it was 1 and the address MSB is 1, the first data byte is not acknowledged, no write strobe is issued, no commit follows, and later bytes are ignored.
- R8: When the sampled wp_i is 0, or the address MSB is 0, write protection has no effect and the byte is written.
- R9: A STOP after at least one accepted data byte produces a single-cycle commit_o. A STOP with no accepted data byte produces none.
- R10: While mem_busy_i is 1, the device address byte is not acknowledged. Once it returns to 0, the same address byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| wp_i | input | 1 | Write-protect level for the upper half of the array |
| mem_busy_i | input | 1 | Array internal write cycle in progress |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| wr_en_o | output | 1 | One-cycle byte-write strobe |
| wr_addr_o | output | ADDR_W | Byte address for the write strobe |
| wr_data_o | output | 8 | Byte data for the write strobe |
| commit_o | output | 1 | One-cycle pulse that starts the internal write cycle |

## Verification
The embedded checks rely on several conditions on the inputs. SCL must stay at each level for several system clocks, so that a synchronised edge of SDA is never mistaken for a clock edge. SDA changes only while SCL is low, except when it forms START and STOP. mem_busy_i must not rise in the middle of a transfer, which is what the check linking write strobes to a quiet memory takes for granted. The host model in the bench keeps each SCL phase at sixteen system clocks and changes its data only in the low phase. The memory model in the bench raises busy only after a commit pulse and holds it well beyond the bus traffic of that transfer.

// File: rtl/ewf_pkg.sv
package ewf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_MUTE
    } ewf_state_e;
endpackage

// File: rtl/ewf_bus_sampler.sv
module ewf_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_pipe = {smp_q.scl_pipe[STAGES-2:0], scl_i};
        smp_d.sda_pipe = {smp_q.sda_pipe[STAGES-2:0], sda_i};
        smp_d.scl_prev = smp_q.scl_pipe[STAGES-1];
        smp_d.sda_prev = smp_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign scl_o      = smp_q.scl_pipe[STAGES-1];
    assign sda_o      = smp_q.sda_pipe[STAGES-1];
    assign scl_rise_o = scl_o & ~smp_q.scl_prev;
    assign scl_fall_o = ~scl_o & smp_q.scl_prev;
    // condition edges only count while the clock was high on both samples
    assign start_o    = scl_o & smp_q.scl_prev & smp_q.sda_prev & ~sda_o;
    assign stop_o     = scl_o & smp_q.scl_prev & ~smp_q.sda_prev & sda_o;
endmodule

// File: rtl/ewf_page_ptr.sv
module ewf_page_ptr #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    logic [ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_i) begin
            ptr_d = load_val_i;
        end else if (step_i) begin
            ptr_d = {ptr_q[ADDR_W-1:PAGE_BITS], ptr_q[PAGE_BITS-1:0] + PAGE_BITS'(1)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (ptr_o[ADDR_W-1:PAGE_BITS] == $past(ptr_o[ADDR_W-1:PAGE_BITS]))); // R6

    logic [PAGE_W-1:0] unused_page_w;
    assign unused_page_w = '0;
endmodule

// File: rtl/eeprom_wr_front.sv
module eeprom_wr_front
    import ewf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         ADDR_W      = 8,
    parameter int         PAGE_BITS   = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wp_i,
    input  logic              mem_busy_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              commit_o
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef struct packed {
        ewf_state_e        state;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  bitcnt;
        logic              oe;
        logic              wp_lat;
        logic              first;
        logic              pend;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
        logic              commit;
    } fe_t;

    fe_t fe_d, fe_q;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic ptr_load, ptr_step;
    logic [ADDR_W-1:0] ptr;
    logic byte_done;

    ewf_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    ewf_page_ptr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ptr_load),
        .load_val_i (fe_q.shreg[ADDR_W-1:0]),
        .step_i     (ptr_step),
        .ptr_o      (ptr)
    );

    // eight bits shifted and the clock has dropped: acknowledge slot begins
    assign byte_done = scl_fall && (fe_q.bitcnt == CNT_W'(BYTE_W));

    always_comb begin
        fe_d        = fe_q;
        fe_d.wr_en  = 1'b0;
        fe_d.commit = 1'b0;
        ptr_load    = 1'b0;
        ptr_step    = 1'b0;

        if (bus_stop) begin
            fe_d.commit = fe_q.pend;
            fe_d.pend   = 1'b0;
            fe_d.state  = ST_IDLE;
            fe_d.oe     = 1'b0;
            fe_d.bitcnt = '0;
        end else if (bus_start) begin
            fe_d.state  = ST_DEV;
            fe_d.oe     = 1'b0;
            fe_d.bitcnt = '0;
        end else begin
            case (fe_q.state)
                ST_DEV, ST_WORD, ST_DATA: begin
                    if (scl_rise) begin
                        fe_d.shreg  = {fe_q.shreg[BYTE_W-2:0], sda_s};
                        fe_d.bitcnt = fe_q.bitcnt + CNT_W'(1);
                    end
                    if (byte_done) begin
                        fe_d.bitcnt = '0;
                        if (fe_q.state == ST_DEV) begin
                            if (fe_q.shreg[7:1] == DEV_ADDR && !fe_q.shreg[0] && !mem_busy_i) begin
                                fe_d.state = ST_DEV_ACK;
                                fe_d.oe    = 1'b1;
                            end else begin
                                fe_d.state = ST_MUTE;
                            end
                        end else if (fe_q.state == ST_WORD) begin
                            fe_d.state = ST_WORD_ACK;
                            fe_d.oe    = 1'b1;
                            ptr_load   = 1'b1;
                        end else if (fe_q.first && fe_q.wp_lat && ptr[ADDR_W-1]) begin
                            fe_d.state = ST_MUTE;
                            fe_d.first = 1'b0;
                        end else begin
                            fe_d.state   = ST_DATA_ACK;
                            fe_d.oe      = 1'b1;
                            fe_d.wr_en   = 1'b1;
                            fe_d.wr_addr = ptr;
                            fe_d.wr_data = fe_q.shreg;
                            fe_d.pend    = 1'b1;
                            fe_d.first   = 1'b0;
                            ptr_step     = 1'b1;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        fe_d.oe    = 1'b0;
                        fe_d.state = ST_WORD;
                    end
                end
                ST_WORD_ACK: begin
                    if (scl_fall) begin
                        fe_d.oe     = 1'b0;
                        fe_d.state  = ST_DATA;
                        fe_d.wp_lat = wp_i;
                        fe_d.first  = 1'b1;
                    end
                end
                ST_DATA_ACK: begin
                    if (scl_fall) begin
                        fe_d.oe    = 1'b0;
                        fe_d.state = ST_DATA;
                    end
                end
                default: begin
                    fe_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe_q       <= '0;
            fe_q.state <= ST_IDLE;
        end else begin
            fe_q <= fe_d;
        end
    end

    assign sda_oe_o  = fe_q.oe;
    assign wr_en_o   = fe_q.wr_en;
    assign wr_addr_o = fe_q.wr_addr;
    assign wr_data_o = fe_q.wr_data;
    assign commit_o  = fe_q.commit;

    AST_START_OPENS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (fe_q.state == ST_DEV)); // R1
    AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_q.state == ST_MUTE) |-> !sda_oe_o); // R2
    AST_DRIVE_IN_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s); // R3
    AST_STROBE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> sda_oe_o); // R5
    AST_WP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && fe_q.wp_lat) |-> !wr_addr_o[ADDR_W-1]); // R7
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o); // R9
    AST_BUSY_NO_ADDR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && fe_q.state == ST_DEV_ACK) |-> !$past(mem_busy_i)); // R10
    AST_BUSY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !mem_busy_i); // R10
endmodule

// File: tb/eeprom_wr_front_test.sv
module eeprom_wr_front_test;
    localparam int Q        = 16;
    localparam int BUSY_CYC = 3000;
    localparam int WDOG     = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_scl = 1'b1;
    logic       host_low = 1'b0;
    logic       wp = 1'b0;
    logic       busy;
    logic       sda_oe, wr_en, commit;
    logic [7:0] wr_addr, wr_data;
    int         busy_cnt;
    int         n_chk = 0;
    int         n_fail = 0;
    int         n_commit = 0;
    logic [15:0] exp_q[$];

    wire sda_line = !(host_low || sda_oe);

    always #2 clk = ~clk;

    eeprom_wr_front uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (host_scl),
        .sda_i      (sda_line),
        .wp_i       (wp),
        .mem_busy_i (busy),
        .sda_oe_o   (sda_oe),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .commit_o   (commit)
    );

    // memory model: busy for a fixed time after each commit
    always @(posedge clk) begin
        if (!rst_n)      busy_cnt <= 0;
        else if (commit) busy_cnt <= BUSY_CYC;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end
    assign busy = (busy_cnt != 0);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && commit) n_commit++;
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R7", "unexpected write strobe", {wr_addr, wr_data}, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check({wr_addr, wr_data} == e, "R4/R5/R6", "write addr/data",
                      {wr_addr, wr_data}, e);
            end
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_low = 1'b0; wait_q();
        host_scl = 1'b1; wait_q();
        host_low = 1'b1; wait_q();
        host_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        host_low = 1'b1; wait_q();
        host_scl = 1'b1; wait_q();
        host_low = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit ack;
        for (int i = 7; i >= 0; i--) begin
            host_low = !b[i]; wait_q();
            host_scl = 1'b1;  wait_q();
            host_scl = 1'b0;  wait_q();
        end
        host_low = 1'b0; wait_q();
        host_scl = 1'b1; wait_q();
        ack = !sda_line;
        host_scl = 1'b0; wait_q();
        check(ack == exp_ack, req, "acknowledge", ack, exp_ack);
        if (exp_ack) check(sda_oe == 1'b0, "R3", "SDA released after ninth clock", sda_oe, 0);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(WDOG * 4);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        check(sda_oe == 0 && wr_en == 0 && commit == 0, "R1", "reset outputs",
              {sda_oe, wr_en, commit}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // single byte write
        bus_start();
        send_byte(8'hA0, 1'b1, "R2");
        send_byte(8'h12, 1'b1, "R4");
        exp_q.push_back(16'h125A);
        send_byte(8'h5A, 1'b1, "R5");
        bus_stop();
        check(n_commit == 1, "R9", "commit after data", n_commit, 1);

        // acknowledge polling while busy
        bus_start();
        send_byte(8'hA0, 1'b0, "R10");
        bus_stop();
        wait_idle();
        bus_start();
        send_byte(8'hA0, 1'b1, "R10");
        bus_stop();
        check(n_commit == 1, "R9", "no commit without data", n_commit, 1);

        // wrong address, then read direction
        bus_start();
        send_byte(8'hA2, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        bus_stop();
        bus_start();
        send_byte(8'hA1, 1'b0, "R2");
        bus_stop();

        // page write with wrap
        bus_start();
        send_byte(8'hA0, 1'b1, "R2");
        send_byte(8'h3E, 1'b1, "R4");
        exp_q.push_back(16'h3E11); send_byte(8'h11, 1'b1, "R6");
        exp_q.push_back(16'h3F22); send_byte(8'h22, 1'b1, "R6");
        exp_q.push_back(16'h3033); send_byte(8'h33, 1'b1, "R6");
        bus_stop();
        check(n_commit == 2, "R9", "commit after page", n_commit, 2);
        wait_idle();

        // protected upper half
        wp = 1'b1;
        bus_start();
        send_byte(8'hA0, 1'b1, "R2");
        send_byte(8'h85, 1'b1, "R4");
        send_byte(8'h77, 1'b0, "R7");
        send_byte(8'h78, 1'b0, "R7");
        bus_stop();
        check(n_commit == 2, "R7", "no commit for refused write", n_commit, 2);

        // lower half unaffected by protection
        bus_start();
        send_byte(8'hA0, 1'b1, "R2");
        send_byte(8'h05, 1'b1, "R4");
        exp_q.push_back(16'h0544);
        send_byte(8'h44, 1'b1, "R8");
        bus_stop();
        check(n_commit == 3, "R8", "commit lower half", n_commit, 3);
        wait_idle();
        wp = 1'b0;

        // unprotected upper half
        bus_start();
        send_byte(8'hA0, 1'b1, "R2");
        send_byte(8'h90, 1'b1, "R4");
        exp_q.push_back(16'h90AB);
        send_byte(8'hAB, 1'b1, "R8");
        bus_stop();
        check(n_commit == 4, "R8", "commit upper half", n_commit, 4);
        wait_idle();

        // repeated START after word address
        bus_start();
        send_byte(8'hA0, 1'b1, "R2");
        send_byte(8'h20, 1'b1, "R4");
        bus_start();
        send_byte(8'hA0, 1'b1, "R1");
        send_byte(8'h40, 1'b1, "R1");
        exp_q.push_back(16'h4099);
        send_byte(8'h99, 1'b1, "R1");
        bus_stop();
        check(n_commit == 5, "R1", "commit after repeated start", n_commit, 5);
        wait_idle();

        check(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule